// File: doc/BRIEF.md
# Segmented Analog Memory Event Manager

This block is the digital controller that sits beside a FIFO-style analog sampling memory made of many short segments. Whenever the self-trigger fires and the capture path is idle, a free segment is claimed in that same clock edge and held in capture for a fixed number of sample ticks. The block never waits for earlier segments to be digitized before it claims one. Each filled segment joins an event queue together with a timestamp latched at the hit. A much slower digitizer takes the segments from that queue strictly in fill order, so random hit arrival is smoothed into a steady readout stream.

A second-level trigger rules on queued events in event order. An accepted event is offered to the digitizer over a valid/ready request that carries the segment index, the cell count and the timestamp. A rejected event is released back to the free pool without any request. Free segments are kept in a circular free list, so released segments are reused in the order they were released. When no segment is free, new hits are dropped and counted.

Top module: `seg_event_mgr`

## Requirements
- R1: After reset no capture is active, the request valid is low, the full flag is low, the drop counter reads 0 and all NUM_SEG segments are free.
- R2: A hit seen while no capture is active and a segment is free starts a capture at that clock edge. Capture-active rises and the segment index shows the oldest free segment. After reset, segments are handed out in the order 0, 1, 2, and so on.
- R3: A capture stays active for exactly SEG_CELLS cycles. A hit that arrives during a capture is ignored: it takes no segment and does not touch the drop counter.
- R4: Finished captures are offered to the digitizer strictly in the order they were filled. Each offer carries the segment index and a cell count equal to SEG_CELLS.
- R5: Each level-2 decision (valid high, accept=1 to keep, accept=0 to reject) applies to the oldest captured entry that has not yet been decided. A decision that arrives when no undecided entry exists is ignored.
- R6: A rejected entry never raises the request valid. Its segment returns to the tail of the free list.
- R7: Only an accepted entry at the head of the queue is offered, with one request outstanding at a time. While valid is high and ready is low, the offer holds stable. Done frees the outstanding segment. Done is ignored while no request is outstanding.
- R8: While no segment is free, full is high. A hit seen with capture idle is then dropped and increments the drop counter, which saturates at 2^DROP_W-1.
- R9: Released segments are reused in the order they were released (circular free list).
- R10: The request carries the value of a free-running cycle counter taken at the hit's clock edge. Two hits G cycles apart therefore carry timestamps that differ by G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Self-trigger hit |
| cap_active_o | output | 1 | A segment is capturing |
| cap_seg_o | output | SEG_W | Index of the segment being captured |
| l2_valid_i | input | 1 | Level-2 decision strobe |
| l2_accept_i | input | 1 | 1 = keep event, 0 = discard |
| req_valid_o | output | 1 | Digitizer request valid |
| req_ready_i | input | 1 | Digitizer takes the request |
| req_seg_o | output | SEG_W | Segment to digitize |
| req_cells_o | output | CELLS_W | Cells in the segment |
| req_ts_o | output | TS_W | Hit timestamp of the event |
| dig_done_i | input | 1 | Digitizer finished the outstanding segment |
| full_o | output | 1 | No free segment |
| drop_cnt_o | output | DROP_W | Saturating count of dropped hits |

## Verification
The collision that matters here is a segment release and a new hit in the same cycle while the pool is empty. The release pops the queue head, and the hit tries to pop the free list. The bench fills every segment, issues a reject, and drives a hit on exactly the edge where the rejected entry leaves the queue. It then expects the hit to be dropped, the drop count to rise by one and full to fall. A hit on the next cycle must then capture into the segment that was just released. A second overlap, a done pulse and a fresh offer being held without ready, is judged by checking that the offer does not change.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // State of the queue head with respect to the digitizer
  typedef enum logic {
    HD_OFFER = 1'b0,  // head may be offered (if accepted)
    HD_WAIT  = 1'b1   // request taken, waiting for done
  } head_st_e;
endpackage

// File: rtl/sem_free_list.sv
module sem_free_list #(
  parameter int NUM_SEG = 128,
  localparam int IDX_W = $clog2(NUM_SEG),
  localparam int CNT_W = $clog2(NUM_SEG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop_i,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic             empty_o
);
  logic [IDX_W-1:0] slot_mem [NUM_SEG];
  logic [NUM_SEG-1:0] touched;
  logic [IDX_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_SEG - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push_i) slot_mem[wr_ptr] <= push_idx_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= CNT_W'(NUM_SEG);
      touched <= '0;
    end else begin
      if (pop_i)  rd_ptr <= step(rd_ptr);
      if (push_i) begin
        wr_ptr          <= step(wr_ptr);
        touched[wr_ptr] <= 1'b1;
      end
      if (pop_i && !push_i)      cnt <= cnt - CNT_W'(1);
      else if (push_i && !pop_i) cnt <= cnt + CNT_W'(1);
    end
  end

  // a slot never rewritten since reset still holds its own index
  assign head_idx_o = touched[rd_ptr] ? slot_mem[rd_ptr] : rd_ptr;
  assign empty_o    = (cnt == '0);

  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> cnt != '0);
  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (rst)
    push_i |-> cnt != CNT_W'(NUM_SEG));
endmodule

// File: rtl/sem_capture.sv
module sem_capture #(
  parameter int NUM_SEG   = 128,
  parameter int SEG_CELLS = 32,
  parameter int TS_W      = 16,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int CELL_W = $clog2(SEG_CELLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             pool_empty_i,
  input  logic [SEG_W-1:0] pool_idx_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic             take_o,
  output logic             drop_o,
  output logic             active_o,
  output logic [SEG_W-1:0] seg_o,
  output logic             fin_o,
  output logic [TS_W-1:0]  fin_ts_o
);
  localparam logic [CELL_W-1:0] LAST = CELL_W'(SEG_CELLS - 1);

  logic             active_q;
  logic [CELL_W-1:0] cell_q;
  logic [SEG_W-1:0] seg_q;
  logic [TS_W-1:0]  ts_q;

  assign take_o = hit_i && !active_q && !pool_empty_i;
  assign drop_o = hit_i && !active_q &&  pool_empty_i;
  assign fin_o  = active_q && (cell_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cell_q   <= '0;
      seg_q    <= '0;
      ts_q     <= '0;
    end else if (take_o) begin
      active_q <= 1'b1;
      cell_q   <= '0;
      seg_q    <= pool_idx_i;
      ts_q     <= ts_i;
    end else if (active_q) begin
      cell_q <= cell_q + CELL_W'(1);
      if (cell_q == LAST) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign seg_o    = seg_q;
  assign fin_ts_o = ts_q;

  assert_capture_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(active_q) |-> $past(cell_q) == LAST);
  assert_hit_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (active_q && cell_q != LAST) |=> active_q && $stable(seg_q) && $stable(ts_q));
endmodule

// File: rtl/sem_event_queue.sv
module sem_event_queue #(
  parameter int DEPTH = 128,
  parameter int SEG_W = 7,
  parameter int TS_W  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_i,
  input  logic [SEG_W-1:0] enq_seg_i,
  input  logic [TS_W-1:0]  enq_ts_i,
  input  logic             dec_i,
  input  logic             dec_acc_i,
  input  logic             pop_i,
  output logic             head_decided_o,
  output logic             head_acc_o,
  output logic [SEG_W-1:0] head_seg_o,
  output logic [TS_W-1:0]  head_ts_o
);
  logic [SEG_W-1:0] seg_mem [DEPTH];
  logic [TS_W-1:0]  ts_mem  [DEPTH];
  logic             acc_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, dec_ptr, rd_ptr;
  logic [CNT_W-1:0] n_und, n_dec;
  logic             dec_take;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // a decision with nothing undecided is dropped
  assign dec_take = dec_i && (n_und != '0);

  always_ff @(posedge clk) begin
    if (enq_i) begin
      seg_mem[wr_ptr] <= enq_seg_i;
      ts_mem[wr_ptr]  <= enq_ts_i;
    end
    if (dec_take) acc_mem[dec_ptr] <= dec_acc_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      dec_ptr <= '0;
      rd_ptr  <= '0;
      n_und   <= '0;
      n_dec   <= '0;
    end else begin
      if (enq_i)    wr_ptr  <= step(wr_ptr);
      if (dec_take) dec_ptr <= step(dec_ptr);
      if (pop_i)    rd_ptr  <= step(rd_ptr);
      n_und <= n_und + CNT_W'(enq_i) - CNT_W'(dec_take);
      n_dec <= n_dec + CNT_W'(dec_take) - CNT_W'(pop_i);
    end
  end

  assign head_decided_o = (n_dec != '0);
  assign head_acc_o     = acc_mem[rd_ptr];
  assign head_seg_o     = seg_mem[rd_ptr];
  assign head_ts_o      = ts_mem[rd_ptr];

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    enq_i |-> (n_und + n_dec) < CNT_W'(DEPTH));
  assert_pop_decided_R5: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> n_dec != '0);
endmodule

// File: rtl/seg_event_mgr.sv
module seg_event_mgr
  import sem_pkg::*;
#(
  parameter int NUM_SEG   = 128,
  parameter int SEG_CELLS = 32,
  parameter int TS_W      = 16,
  parameter int DROP_W    = 8,
  localparam int SEG_W   = $clog2(NUM_SEG),
  localparam int CELLS_W = $clog2(SEG_CELLS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_i,
  output logic               cap_active_o,
  output logic [SEG_W-1:0]   cap_seg_o,
  input  logic               l2_valid_i,
  input  logic               l2_accept_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [SEG_W-1:0]   req_seg_o,
  output logic [CELLS_W-1:0] req_cells_o,
  output logic [TS_W-1:0]    req_ts_o,
  input  logic               dig_done_i,
  output logic               full_o,
  output logic [DROP_W-1:0]  drop_cnt_o
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [SEG_W-1:0] pool_idx, head_seg;
  logic             pool_empty, take, drop, fin;
  logic [TS_W-1:0]  fin_ts, head_ts, ts_q;
  logic             head_decided, head_acc;
  logic             rel_reject, rel_done, release_seg, fire;
  logic [DROP_W-1:0] drop_q;
  head_st_e         head_st;

  sem_free_list #(.NUM_SEG(NUM_SEG)) i_pool (
    .clk(clk), .rst(rst),
    .pop_i(take), .push_i(release_seg), .push_idx_i(head_seg),
    .head_idx_o(pool_idx), .empty_o(pool_empty)
  );

  sem_capture #(.NUM_SEG(NUM_SEG), .SEG_CELLS(SEG_CELLS), .TS_W(TS_W)) i_cap (
    .clk(clk), .rst(rst),
    .hit_i(hit_i), .pool_empty_i(pool_empty), .pool_idx_i(pool_idx), .ts_i(ts_q),
    .take_o(take), .drop_o(drop), .active_o(cap_active_o), .seg_o(cap_seg_o),
    .fin_o(fin), .fin_ts_o(fin_ts)
  );

  sem_event_queue #(.DEPTH(NUM_SEG), .SEG_W(SEG_W), .TS_W(TS_W)) i_queue (
    .clk(clk), .rst(rst),
    .enq_i(fin), .enq_seg_i(cap_seg_o), .enq_ts_i(fin_ts),
    .dec_i(l2_valid_i), .dec_acc_i(l2_accept_i), .pop_i(release_seg),
    .head_decided_o(head_decided), .head_acc_o(head_acc),
    .head_seg_o(head_seg), .head_ts_o(head_ts)
  );

  // head handling: reject frees at once, accept goes through the digitizer
  assign req_valid_o = head_decided && head_acc && (head_st == HD_OFFER);
  assign fire        = req_valid_o && req_ready_i;
  assign rel_reject  = head_decided && !head_acc;
  assign rel_done    = (head_st == HD_WAIT) && dig_done_i;
  assign release_seg = rel_reject || rel_done;

  assign req_seg_o   = head_seg;
  assign req_ts_o    = head_ts;
  assign req_cells_o = CELLS_W'(SEG_CELLS);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_st <= HD_OFFER;
      ts_q    <= '0;
      drop_q  <= '0;
    end else begin
      ts_q <= ts_q + TS_W'(1);
      if (fire)          head_st <= HD_WAIT;
      else if (rel_done) head_st <= HD_OFFER;
      if (drop && drop_q != DROP_MAX) drop_q <= drop_q + DROP_W'(1);
    end
  end

  assign full_o     = pool_empty;
  assign drop_cnt_o = drop_q;

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i) |=> req_valid_o && $stable(req_seg_o) && $stable(req_ts_o));
  assert_drop_count_R8: assert property (@(posedge clk) disable iff (rst)
    (full_o && hit_i && !cap_active_o && drop_cnt_o != DROP_MAX)
      |=> drop_cnt_o == $past(drop_cnt_o) + DROP_W'(1));
  assert_full_no_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (full_o && hit_i && !cap_active_o) |=> !cap_active_o);
  assert_done_frees_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && req_ready_i) |=> !req_valid_o);
endmodule

// File: tb/test_seg_event_mgr.sv
`timescale 1ns/1ps
module test_seg_event_mgr;
  localparam int NSEG = 128, CELLS = 32, TSW = 16, DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, hit = 1'b0, l2_v = 1'b0, l2_a = 1'b0, rdy = 1'b0, done = 1'b0;
  logic cap_act, req_v, full;
  logic [6:0] cap_seg, req_seg;
  logic [5:0] req_cells;
  logic [TSW-1:0] req_ts, ts0;
  logic [DW-1:0] drop;

  seg_event_mgr #(.NUM_SEG(NSEG), .SEG_CELLS(CELLS), .TS_W(TSW), .DROP_W(DW)) i_seg_event_mgr (
    .clk(clk), .rst(rst), .hit_i(hit), .cap_active_o(cap_act), .cap_seg_o(cap_seg),
    .l2_valid_i(l2_v), .l2_accept_i(l2_a), .req_valid_o(req_v), .req_ready_i(rdy),
    .req_seg_o(req_seg), .req_cells_o(req_cells), .req_ts_o(req_ts),
    .dig_done_i(done), .full_o(full), .drop_cnt_o(drop)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, ca = 0, cb = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic pulse_hit; hit = 1'b1; tick; hit = 1'b0; endtask
  task automatic wait_idle; while (cap_act) tick; endtask
  task automatic decide(input logic acc); l2_v = 1'b1; l2_a = acc; tick; l2_v = 1'b0; endtask

  task automatic t_reset;
    rst = 1'b1; repeat (4) tick; rst = 1'b0; tick;
    chk("R1 active", int'(cap_act), 0);
    chk("R1 req_valid", int'(req_v), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 drop", int'(drop), 0);
    decide(1'b0);  // R5: nothing undecided, must be ignored
  endtask

  task automatic t_capture;
    int len;
    ca = cyc; pulse_hit;
    chk("R2 active", int'(cap_act), 1);
    chk("R2 first seg", int'(cap_seg), 0);
    len = 1;
    while (1) begin
      hit = (len == 5);
      tick;
      if (!cap_act) break;
      len++;
    end
    hit = 1'b0;
    chk("R3 capture length", len, CELLS);
    chk("R3 ignored hit no drop", int'(drop), 0);
    cb = cyc; pulse_hit;
    chk("R3 ignored hit kept pool order", int'(cap_seg), 1);
    wait_idle;
  endtask

  task automatic t_order;
    chk("R7 undecided not offered", int'(req_v), 0);
    decide(1'b1);
    chk("R5 first decision hits oldest", int'(req_v), 1);
    chk("R4 order seg", int'(req_seg), 0);
    chk("R4 cells", int'(req_cells), CELLS);
    ts0 = req_ts;
    repeat (3) tick;
    done = 1'b1; tick; done = 1'b0;
    chk("R7 hold valid", int'(req_v), 1);
    chk("R7 hold seg / done ignored", int'(req_seg), 0);
    rdy = 1'b1; tick; rdy = 1'b0;
    chk("R7 taken", int'(req_v), 0);
    decide(1'b1); tick;
    chk("R7 one outstanding", int'(req_v), 0);
    done = 1'b1; tick; done = 1'b0;
    chk("R4 second offer", int'(req_v), 1);
    chk("R4 second seg", int'(req_seg), 1);
    chk("R10 ts delta", int'(req_ts - ts0), (cb - ca) & 16'hFFFF);
    rdy = 1'b1; tick; rdy = 1'b0;
    done = 1'b1; tick; done = 1'b0;
    chk("R7 drained", int'(req_v), 0);
  endtask

  task automatic t_reject;
    pulse_hit; chk("R2 seg2", int'(cap_seg), 2); wait_idle;
    pulse_hit; chk("R2 seg3", int'(cap_seg), 3); wait_idle;
    l2_v = 1'b1; l2_a = 1'b0; tick;
    chk("R6 rejected head not offered", int'(req_v), 0);
    l2_a = 1'b1; tick; l2_v = 1'b0;
    chk("R6 skip to accepted", int'(req_v), 1);
    chk("R6 skipped seg", int'(req_seg), 3);
    rdy = 1'b1; tick; rdy = 1'b0;
    done = 1'b1; tick; done = 1'b0;
  endtask

  task automatic t_fill;
    for (int i = 0; i < NSEG; i++) begin
      pulse_hit;
      chk("R9 reuse order", int'(cap_seg), (i < NSEG - 4) ? i + 4 : i - (NSEG - 4));
      wait_idle;
    end
    chk("R8 full", int'(full), 1);
    repeat (3) pulse_hit;
    chk("R8 drops counted", int'(drop), 3);
    chk("R8 no capture when full", int'(cap_act), 0);
  endtask

  task automatic t_collide;
    int d0;
    d0 = int'(drop);
    l2_v = 1'b1; l2_a = 1'b0; tick; l2_v = 1'b0;
    hit = 1'b1; tick; hit = 1'b0;
    chk("R8 same-cycle hit dropped", int'(drop), d0 + 1);
    chk("R8 same-cycle no capture", int'(cap_act), 0);
    chk("R6 released clears full", int'(full), 0);
    pulse_hit;
    chk("R9 released seg reused", int'(cap_seg), 4);
    wait_idle;
    chk("R8 full again", int'(full), 1);
  endtask

  task automatic t_saturate;
    hit = 1'b1; repeat (300) tick; hit = 1'b0;
    chk("R8 saturation", int'(drop), 255);
  endtask

  task automatic t_drain;
    int seen;
    seen = 0;
    l2_v = 1'b1; l2_a = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      tick;
      if (req_v) seen++;
    end
    l2_v = 1'b0; tick;
    chk("R6 no request for rejects", seen, 0);
    chk("R6 all freed", int'(full), 0);
    decide(1'b1);  // R5: nothing undecided, ignored
    pulse_hit;
    chk("R9 order after drain", int'(cap_seg), 5);
    wait_idle; tick;
    chk("R5 stray decision ignored", int'(req_v), 0);
    decide(1'b1);
    chk("R5 real decision", int'(req_v), 1);
  endtask

  initial begin
    t_reset;
    t_capture;
    t_order;
    t_reject;
    t_fill;
    t_collide;
    t_saturate;
    t_drain;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule